// File: doc/BRIEF.md
# Serial receive capture with mode-dependent buffer transfer

This block is the receive half of a two-wire serial port in which another device drives the serial clock. Each frame has nine clock pulses. The first eight carry a data byte, most significant bit first. The ninth carries the acknowledge level. Both wires are brought into the system clock domain through flop synchronisers. The data line is sampled whenever the synchronised clock line goes from low to high.

Two mode inputs control when the shifted bits are copied into a 16-bit receive buffer and how they are arranged there. They also control which strobes fire:

- **Interrupt-select low:** one copy is made at the end of the frame. An acknowledge or a not-acknowledge strobe is raised, depending on the ninth bit.
- **Interrupt-select high:** a copy is made after the eighth bit, using a rotated layout. The ninth bit raises a transmit strobe.
- **Interrupt-select high and phase input high:** the ninth bit also triggers a second copy in the plain layout, which overwrites the first.

A frame-restart input puts the bit count back to the start of a frame.

Top module: `srx_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rbuf_data` is 0 and every strobe output is 0.
- R2: A frame is nine rising edges of the synchronised clock line, and the data line is sampled on each one. The first eight samples are D7 down to D0 and the ninth is D8. Any result of a given edge shows at the outputs three clock cycles after the input change that caused it.
- R3: With `mode_irqsel`=0, the ninth edge loads `rbuf_data` with bit 8 = D8 and bits 7..0 = D7..D0.
- R4: With `mode_irqsel`=0, the ninth edge pulses `ack_irq` together with `dma_req` when D8=0. When D8=1 it pulses `nack_irq`, and `dma_req` stays low.
- R5: With `mode_irqsel`=1, the eighth edge loads `rbuf_data` with bit 8 = D0, bits 7..1 = D7..D1 and bit 0 = 0. The same edge pulses `rx_irq` and `dma_req`.
- R6: With `mode_irqsel`=1, the ninth edge pulses `tx_irq`.
- R7: With `mode_irqsel`=1 and `mode_phase`=1, the ninth edge also reloads `rbuf_data` in the layout of R3.
- R8: With `mode_irqsel`=1 and `mode_phase`=0, the ninth edge leaves `rbuf_data` unchanged.
- R9: Bits 15..9 of `rbuf_data` are always 0.
- R10: Each strobe lasts exactly one cycle. At most one of `ack_irq`, `nack_irq`, `rx_irq` and `tx_irq` is high in any cycle.
- R11: A cycle with `frame_restart` high discards any partial frame, so the next rising edge is taken as D7.
- R12: With `mode_irqsel`=0, the value of `mode_phase` has no effect on the buffer or on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Serial clock line, driven by the remote device and asynchronous to `clk` |
| sda_in | input | 1 | Serial data line, asynchronous to `clk` |
| frame_restart | input | 1 | Returns the bit count to the start of a frame |
| mode_irqsel | input | 1 | Selects between the end-of-frame transfer and the eighth-bit transfer |
| mode_phase | input | 1 | When `mode_irqsel` is 1, enables the second copy at the ninth bit |
| rbuf_data | output | 16 | Receive buffer |
| ack_irq | output | 1 | Acknowledge strobe |
| nack_irq | output | 1 | Not-acknowledge strobe |
| rx_irq | output | 1 | Receive strobe at the eighth bit |
| tx_irq | output | 1 | Transmit strobe at the ninth bit |
| dma_req | output | 1 | DMA request strobe |

## Verification
If the bit counter is off by one, the transfer and the strobes land one SCL period early or late. The reference model sees this three cycles after the edge that was miscounted. A fault in the shift register shows as a wrong or shifted byte in `rbuf_data` at the very next transfer point. A mode decoding fault shows up as a strobe of the wrong kind, or as a buffer that is rotated when it should not be. Such faults are caught in the same cycle by the comparison that runs every clock. A stuck restart shows up only in the frame that follows the restart, as a misaligned byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W     = 8;
  localparam int BUF_W      = 16;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic irqsel;
    logic phase;
  } srx_mode_t;

  typedef struct packed {
    logic ack;
    logic nack;
    logic rx;
    logic tx;
    logic dma;
  } srx_strobe_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RESET_VAL;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= RESET_VAL;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              scl,
  input  logic              sda,
  output logic              byte_done,
  output logic              frame_done,
  output logic [DATA_W-1:0] byte_word,
  output logic [DATA_W-1:0] held_word,
  output logic              ack_bit
);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W);

  logic              scl_q;
  logic              rise;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;

  assign rise = scl & ~scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      scl_q <= scl;
      if (rise) shreg <= {shreg[DATA_W-2:0], sda};
      if (restart)                       cnt <= '0;
      else if (rise && cnt == LAST_BIT)  cnt <= '0;
      else if (rise)                     cnt <= cnt + 1'b1;
    end
  end

  assign byte_done  = rise & ~restart & (cnt == LAST_DATA);
  assign frame_done = rise & ~restart & (cnt == LAST_BIT);
  assign byte_word  = {shreg[DATA_W-2:0], sda};
  assign held_word  = shreg;
  assign ack_bit    = sda;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_BIT); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R11
endmodule

// File: rtl/srx_rbuf.sv
module srx_rbuf
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  srx_mode_t         mode,
  input  logic              byte_done,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] byte_word,
  input  logic [DATA_W-1:0] held_word,
  input  logic              ack_bit,
  output logic [BUF_W-1:0]  rbuf,
  output srx_strobe_t       strobe
);
  localparam int LAYOUT_W = DATA_W + 1;

  logic [LAYOUT_W-1:0] plain_img;
  logic [LAYOUT_W-1:0] rot_img;

  // plain: ack on top, byte below; rotated: lsb on top, remaining bits, zero
  assign plain_img = {ack_bit, held_word};
  assign rot_img   = {byte_word[0], byte_word[DATA_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      rbuf   <= '0;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (byte_done && mode.irqsel) begin
        rbuf       <= BUF_W'(rot_img);
        strobe.rx  <= 1'b1;
        strobe.dma <= 1'b1;
      end
      if (frame_done) begin
        if (!mode.irqsel) begin
          rbuf        <= BUF_W'(plain_img);
          strobe.ack  <= ~ack_bit;
          strobe.nack <= ack_bit;
          strobe.dma  <= ~ack_bit;
        end else begin
          strobe.tx <= 1'b1;
          if (mode.phase) rbuf <= BUF_W'(plain_img);
        end
      end
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rbuf[BUF_W-1:LAYOUT_W] == '0); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.ack, strobe.nack, strobe.rx, strobe.tx})); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe.ack |=> !strobe.ack); // R10
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe.rx |=> !strobe.rx); // R10
  AST_NACK_NO_DMA: assert property (@(posedge clk) disable iff (rst)
    strobe.nack |-> !strobe.dma); // R4
  AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (rst)
    strobe.dma |-> (strobe.ack || strobe.rx)); // R4
  AST_TX_MODE: assert property (@(posedge clk) disable iff (rst)
    strobe.tx |-> $past(mode.irqsel)); // R6
  AST_HOLD_NO_PHASE: assert property (@(posedge clk) disable iff (rst)
    (strobe.tx && !$past(mode.phase)) |-> $stable(rbuf)); // R8
endmodule

// File: rtl/srx_capture.sv
module srx_capture
  import srx_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int BW    = BUF_W,
  parameter int SYNCN = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          frame_restart,
  input  logic          mode_irqsel,
  input  logic          mode_phase,
  output logic [BW-1:0] rbuf_data,
  output logic          ack_irq,
  output logic          nack_irq,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          dma_req
);
  logic [1:0]    line_sync;
  logic          byte_done, frame_done, ack_bit;
  logic [DW-1:0] byte_word, held_word;
  srx_mode_t     mode;
  srx_strobe_t   strobe;

  assign mode.irqsel = mode_irqsel;
  assign mode.phase  = mode_phase;

  srx_sync #(.WIDTH(2), .STAGES(SYNCN), .RESET_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (line_sync)
  );

  srx_shifter #(.DATA_W(DW)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .restart    (frame_restart),
    .scl        (line_sync[1]),
    .sda        (line_sync[0]),
    .byte_done  (byte_done),
    .frame_done (frame_done),
    .byte_word  (byte_word),
    .held_word  (held_word),
    .ack_bit    (ack_bit)
  );

  srx_rbuf #(.DATA_W(DW), .BUF_W(BW)) u_rbuf (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .byte_done  (byte_done),
    .frame_done (frame_done),
    .byte_word  (byte_word),
    .held_word  (held_word),
    .ack_bit    (ack_bit),
    .rbuf       (rbuf_data),
    .strobe     (strobe)
  );

  assign ack_irq  = strobe.ack;
  assign nack_irq = strobe.nack;
  assign rx_irq   = strobe.rx;
  assign tx_irq   = strobe.tx;
  assign dma_req  = strobe.dma;
endmodule

// File: tb/srx_capture_test.sv
module srx_capture_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        scl_in = 1'b1, sda_in = 1'b1, frame_restart = 1'b0;
  logic        mode_irqsel = 1'b0, mode_phase = 1'b0;
  logic [15:0] rbuf_data;
  logic        ack_irq, nack_irq, rx_irq, tx_irq, dma_req;

  srx_capture uut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .frame_restart(frame_restart), .mode_irqsel(mode_irqsel),
    .mode_phase(mode_phase), .rbuf_data(rbuf_data), .ack_irq(ack_irq),
    .nack_irq(nack_irq), .rx_irq(rx_irq), .tx_irq(tx_irq), .dma_req(dma_req)
  );

  typedef struct {
    int          due;
    logic        upd;
    logic [15:0] bval;
    logic [4:0]  stb;   // {ack, nack, rx, tx, dma}
    string       tag;
    string       btag;
  } ev_t;

  int    checks = 0, errors = 0, cyc = 0;
  bit    finished = 0;
  ev_t   pend[$];
  logic  bits_q[$];
  logic [15:0] exp_buf = '0;
  string buf_tag = "R1";
  string scen = "R1";
  logic  scl_now = 1'b1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) %s cycle %0d actual %h expected %h",
               tag, scen, what, cyc, act, exp);
    end
  endtask

  task automatic model_rise(logic s);
    ev_t e;
    logic [7:0] w = '0;
    bits_q.push_back(s);
    if (bits_q.size() >= 8)
      for (int i = 0; i < 8; i++) w = {w[6:0], bits_q[i]};
    e.due = cyc + 3; e.upd = 1'b0; e.bval = '0; e.stb = '0; e.tag = ""; e.btag = "";
    if (bits_q.size() == 8 && mode_irqsel) begin
      e.upd = 1'b1; e.bval = {7'b0, w[0], w[7:1], 1'b0};
      e.stb = 5'b00101; e.tag = "R5"; e.btag = "R5";
      pend.push_back(e);
    end else if (bits_q.size() == 9) begin
      if (!mode_irqsel) begin
        e.upd = 1'b1; e.bval = {7'b0, bits_q[8], w};
        e.stb = bits_q[8] ? 5'b01000 : 5'b10001;
        e.tag = "R4"; e.btag = "R3";
      end else begin
        e.stb = 5'b00010; e.tag = "R6";
        if (mode_phase) begin
          e.upd = 1'b1; e.bval = {7'b0, bits_q[8], w}; e.btag = "R7";
        end else e.btag = "R8";
      end
      pend.push_back(e);
      bits_q.delete();
    end
  endtask

  task automatic tick(logic scl_v, logic sda_v, logic rs_v);
    logic [4:0] estb = '0;
    string stag = "R10";
    @(negedge clk);
    cyc++;
    if (pend.size() > 0 && pend[0].due == cyc) begin
      ev_t e = pend.pop_front();
      if (e.upd) exp_buf = e.bval;
      buf_tag = e.btag;
      estb = e.stb;
      stag = e.tag;
    end
    check(buf_tag, 32'(rbuf_data), 32'(exp_buf), "rbuf_data");
    check(stag, 32'({ack_irq, nack_irq, rx_irq, tx_irq, dma_req}), 32'(estb), "strobes");
    scl_in = scl_v; sda_in = sda_v; frame_restart = rs_v;
    if (rs_v) bits_q.delete();
    if (!rst && scl_v && !scl_now) model_rise(sda_v);
    scl_now = scl_v;
  endtask

  task automatic send_bit(logic b);
    for (int i = 0; i < 4; i++) tick(1'b0, b, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1, b, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b0);
  endtask

  task automatic send_frame(logic [7:0] d, logic d8);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(d8);
    idle(6);
    check("R9", 32'(rbuf_data[15:9]), 32'h0, "upper buffer bits");
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b0);
    rst = 1'b0;
    idle(4);
    check("R1", 32'(rbuf_data), 32'h0, "buffer after reset");

    scen = "R3"; mode_irqsel = 1'b0; mode_phase = 1'b0;
    send_frame(8'hA5, 1'b0);           // ack path, R4
    scen = "R4";
    send_frame(8'h3C, 1'b1);           // nack path
    scen = "R12"; mode_phase = 1'b1;
    idle(4);
    send_frame(8'h81, 1'b0);
    send_frame(8'h7E, 1'b1);
    scen = "R8"; mode_irqsel = 1'b1; mode_phase = 1'b0;
    idle(4);
    send_frame(8'hC3, 1'b1);           // R5 rotated copy, R6 tx, R8 hold
    scen = "R7"; mode_phase = 1'b1;
    idle(4);
    send_frame(8'h5A, 1'b0);           // R5 then R7 second copy
    send_frame(8'h01, 1'b1);
    scen = "R11"; mode_irqsel = 1'b0; mode_phase = 1'b0;
    idle(4);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    idle(6);
    tick(1'b1, 1'b1, 1'b1);
    idle(6);
    send_frame(8'h96, 1'b0);
    idle(8);
    check("R2", 32'(pend.size()), 32'h0, "pending events drained");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule